// File: doc/BRIEF.md
# Audio DMA Global Control and Reset Block

This block holds the global registers that sit above three audio DMA channels (input, output and microphone). It contains a 32-bit global control register, a read-only global status register and a one-byte access semaphore. It sits on a simple register bus. A write is one cycle with `bus_wr` high, the byte offset on `bus_addr` and the access width on `bus_size`. Reads are combinational from `bus_addr`.

While cold reset is in force (control bit 1 low), the block blocks every bus write. The one exception is a full 32-bit write to global control. The block also tells the channel register files whether they may accept a write. Writing global control with bit 1 low sends a one-cycle reset pulse to all channels. Writing it with bit 2 high sends a one-cycle warm-reset pulse, but only when no channel is running, and the bit then clears itself. The block decodes the output channel count from control bits 21:20. It merges the three channel interrupt requests into status bits and into one level interrupt line, which an acknowledge input drops for one cycle.

Top module: `audio_glob_ctrl`

## Requirements
- R1: After reset, global control (offset 0x2C) reads 0x0000_0000, global status (0x30) reads 0x0000_0100 (bit 8 is codec ready), the semaphore (0x34) reads 0, `cold_active_o` is 1 and `out_chans_o` is 2.
- R2: While `cold_active_o` is 1, every write other than a 32-bit (`bus_size`=2) write to 0x2C is discarded. This includes byte writes to 0x2C and 0x34. `chan_wr_en_o` stays 0 for writes to channel offsets below 0x2C.
- R3: Once control bit 1 is 1, `cold_active_o` is 0. A write to an offset below 0x2C then drives `chan_wr_en_o` high in the same cycle.
- R4: A 32-bit control write with bits 1 and 2 set while `ch_run` is 0 stores the value with bit 2 cleared and pulses `warm_rst_o` for one cycle. For example, 0x76 reads back as 0x72. If any `ch_run` bit is 1, no pulse occurs and the value is stored unchanged.
- R5: Once cold reset is released, the interrupt-enable field (bits 6:4) is freely writable. For example, 0x72 reads back as 0x72.
- R6: A 32-bit control write with bit 1 clear stores the value with bits 2:1 cleared, clears the semaphore and pulses `chan_rst_o` for one cycle. For example, 0x70 reads back as 0x70.
- R7: `out_chans_o` is 2, 4, 6 or 2 for control bits 21:20 equal to 0, 1, 2 or 3.
- R8: Global status bits 5, 6 and 7 follow `ch_irq[0]` (input), `ch_irq[1]` (output) and `ch_irq[2]` (microphone) one cycle later. `irq_o` is the registered OR of `ch_irq`.
- R9: `irq_o` is 0 in the cycle after an `irq_ack` pulse. It rises again on the following edge if any request is still pending.
- R10: The semaphore is written by a byte write to 0x34 when cold reset is released. Writes to 0x30 or to unmapped offsets change nothing. Reads of any offset other than 0x2C, 0x30 and 0x34 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset |
| bus_size | input | 2 | 0 byte, 1 word, 2 long |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| ch_run | input | 3 | Channel running flags (input, output, mic) |
| ch_irq | input | 3 | Channel interrupt requests (input, output, mic) |
| irq_ack | input | 1 | Interrupt acknowledge / resample |
| cold_active_o | output | 1 | Cold reset in force |
| chan_wr_en_o | output | 1 | Channel register write allowed |
| chan_rst_o | output | 1 | One-cycle channel reset pulse |
| warm_rst_o | output | 1 | One-cycle warm reset pulse |
| out_chans_o | output | 3 | Output channel count |
| irq_o | output | 1 | Level interrupt |

## Verification
Register contents, `cold_active_o` and `out_chans_o` change on the clock edge that takes the write. The bench reads them at the following falling edge. `chan_rst_o` and `warm_rst_o` are high for exactly the cycle after that edge, so the bench samples them at that falling edge and again one cycle later to see them fall. `chan_wr_en_o` is combinational, so it is sampled before the write edge. Status bits and `irq_o` lag `ch_irq` and `irq_ack` by one edge, and every sweep step checks them one falling edge after the inputs change.

// File: rtl/audio_glob_ctrl.sv
module audio_glob_ctrl #(
  parameter int          AW          = 8,
  parameter logic [31:0] STABLE_MASK = 32'hFFFF_FFF9,
  parameter logic [31:0] STA_RESET   = 32'h0000_0100,
  parameter logic [AW-1:0] CTL_OFS   = 8'h2C,
  parameter logic [AW-1:0] STA_OFS   = 8'h30,
  parameter logic [AW-1:0] SEM_OFS   = 8'h34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [1:0]    bus_size,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [2:0]    ch_run,
  input  logic [2:0]    ch_irq,
  input  logic          irq_ack,
  output logic          cold_active_o,
  output logic          chan_wr_en_o,
  output logic          chan_rst_o,
  output logic          warm_rst_o,
  output logic [2:0]    out_chans_o,
  output logic          irq_o
);
  localparam int WARM_BIT = 2;
  localparam int COLD_BIT = 1;

  logic [31:0] ctl_q;
  logic [7:0]  sem_q;
  logic [2:0]  sta_q;
  logic        cold;
  logic        ctl_wr, sem_wr, warm_ok;

  assign cold    = ~ctl_q[COLD_BIT];
  assign ctl_wr  = bus_wr && bus_addr == CTL_OFS && bus_size == 2'd2;
  assign sem_wr  = bus_wr && bus_addr == SEM_OFS && bus_size == 2'd0 && !cold;
  assign warm_ok = bus_wdata[COLD_BIT] && bus_wdata[WARM_BIT] && ch_run == 3'b000;

  assign cold_active_o = cold;
  assign chan_wr_en_o  = bus_wr && !cold && bus_addr < CTL_OFS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      sem_q      <= '0;
      chan_rst_o <= 1'b0;
      warm_rst_o <= 1'b0;
    end else begin
      chan_rst_o <= 1'b0;
      warm_rst_o <= 1'b0;
      if (ctl_wr) begin
        if (!bus_wdata[COLD_BIT]) begin
          ctl_q      <= bus_wdata & STABLE_MASK;
          sem_q      <= '0;
          chan_rst_o <= 1'b1;
        end else if (warm_ok) begin
          ctl_q      <= bus_wdata & ~(32'd1 << WARM_BIT);
          warm_rst_o <= 1'b1;
        end else begin
          ctl_q <= bus_wdata;
        end
      end else if (sem_wr) begin
        sem_q <= bus_wdata[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_q <= '0;
      irq_o <= 1'b0;
    end else begin
      sta_q <= ch_irq;
      irq_o <= (|ch_irq) & ~irq_ack;
    end
  end

  always_comb begin
    case (ctl_q[21:20])
      2'd1:    out_chans_o = 3'd4;
      2'd2:    out_chans_o = 3'd6;
      default: out_chans_o = 3'd2;
    endcase
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTL_OFS)      bus_rdata = ctl_q;
    else if (bus_addr == STA_OFS) bus_rdata = STA_RESET | {24'd0, sta_q, 5'd0};
    else if (bus_addr == SEM_OFS) bus_rdata = {24'd0, sem_q};
  end
endmodule

// File: rtl/audio_glob_ctrl_chk.sv
module audio_glob_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_rdata,
  input logic [2:0]  ch_run,
  input logic [2:0]  ch_irq,
  input logic        irq_ack,
  input logic        cold_active_o,
  input logic        chan_wr_en_o,
  input logic        chan_rst_o,
  input logic        warm_rst_o,
  input logic [2:0]  out_chans_o,
  input logic        irq_o
);
  logic started;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;

  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cold_active_o |-> !chan_wr_en_o);
  p_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !cold_active_o && bus_addr < 8'h2C) |-> chan_wr_en_o);
  p_warm_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (started && warm_rst_o) |-> ($past(ch_run) == 3'b000 && !cold_active_o));
  p_warm_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst_o |-> !chan_rst_o);
  p_cold_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst_o |-> cold_active_o);
  p_chans_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_chans_o == 3'd2 || out_chans_o == 3'd4 || out_chans_o == 3'd6));
  p_sta_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (started && bus_addr == 8'h30) |-> bus_rdata[7:5] == $past(ch_irq));
  p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_o);
  p_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !$past(irq_ack) && |$past(ch_irq)) |-> irq_o);
endmodule

bind audio_glob_ctrl audio_glob_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .ch_run(ch_run), .ch_irq(ch_irq), .irq_ack(irq_ack),
  .cold_active_o(cold_active_o), .chan_wr_en_o(chan_wr_en_o),
  .chan_rst_o(chan_rst_o), .warm_rst_o(warm_rst_o),
  .out_chans_o(out_chans_o), .irq_o(irq_o)
);

// File: tb/audio_glob_ctrl_tb.sv
`timescale 1ns/1ps
module audio_glob_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [1:0] bus_size = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [2:0] ch_run = 0, ch_irq = 0;
  logic irq_ack = 0;
  logic cold_active_o, chan_wr_en_o, chan_rst_o, warm_rst_o, irq_o;
  logic [2:0] out_chans_o;
  int checks = 0, fails = 0;
  logic seen_wren, seen_crst, seen_warm;

  always #4 clk = ~clk;

  audio_glob_ctrl u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_size = s; bus_wdata = d;
    #1 seen_wren = chan_wr_en_o;
    @(negedge clk);
    seen_crst = chan_rst_o; seen_warm = warm_rst_o;
    bus_wr = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1 chk(req, bus_rdata, exp);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd("R1 ctl", 8'h2C, 32'h0);
    rd("R1 sta", 8'h30, 32'h100);
    rd("R1 sem", 8'h34, 32'h0);
    chk("R1 cold", cold_active_o, 1);
    chk("R1 chans", out_chans_o, 2);

    wr(8'h00, 2, 32'h5555_555F);
    chk("R2 chan gate", seen_wren, 0);
    wr(8'h34, 0, 32'hAB);
    rd("R2 sem blocked", 8'h34, 0);
    wr(8'h2C, 0, 32'h02);
    rd("R2 byte ctl blocked", 8'h2C, 0);
    chk("R2 still cold", cold_active_o, 1);

    wr(8'h2C, 2, 32'h02);
    rd("R3 ctl", 8'h2C, 32'h02);
    chk("R3 cold off", cold_active_o, 0);
    wr(8'h10, 2, 32'h1234);
    chk("R3 chan open", seen_wren, 1);

    wr(8'h2C, 2, 32'h72);
    rd("R5 enables", 8'h2C, 32'h72);

    wr(8'h34, 0, 32'h5A);
    rd("R10 sem", 8'h34, 32'h5A);

    wr(8'h2C, 2, 32'h76);
    rd("R4 warm clear", 8'h2C, 32'h72);
    chk("R4 warm pulse", seen_warm, 1);
    @(negedge clk); chk("R4 pulse falls", warm_rst_o, 0);
    ch_run = 3'b010;
    wr(8'h2C, 2, 32'h76);
    rd("R4 busy stored", 8'h2C, 32'h76);
    chk("R4 busy no pulse", seen_warm, 0);
    ch_run = 0;
    rd("R4 sem kept", 8'h34, 32'h5A);

    wr(8'h30, 2, 32'hFFFF_FFFF);
    rd("R10 sta ro", 8'h30, 32'h100);
    wr(8'h38, 2, 32'hFFFF_FFFF);
    rd("R10 unmapped", 8'h38, 0);
    rd("R10 chan ofs", 8'h00, 0);
    rd("R10 ctl kept", 8'h2C, 32'h76);

    wr(8'h2C, 2, 32'h70);
    rd("R6 ctl", 8'h2C, 32'h70);
    rd("R6 sem cleared", 8'h34, 0);
    chk("R6 pulse", seen_crst, 1);
    chk("R6 cold", cold_active_o, 1);
    @(negedge clk); chk("R6 pulse falls", chan_rst_o, 0);

    for (int f = 0; f < 4; f++) begin
      wr(8'h2C, 2, (32'(f) << 20) | 32'h2);
      chk("R7 chans", out_chans_o, (f == 1) ? 4 : (f == 2) ? 6 : 2);
    end

    for (int v = 0; v < 8; v++) begin
      ch_irq = 3'(v);
      @(negedge clk);
      rd("R8 sta", 8'h30, 32'h100 | (32'(v) << 5));
      chk("R8 irq", irq_o, (v != 0));
    end

    ch_irq = 3'b100;
    @(negedge clk);
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
    chk("R9 drop", irq_o, 0);
    @(negedge clk);
    chk("R9 reassert", irq_o, 1);
    ch_irq = 0;
    @(negedge clk);
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
    @(negedge clk);
    chk("R9 idle", irq_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule